// File: doc/BRIEF.md
# Self-Synchronizing Payload Scrambler and Descrambler

This block holds the two halves of a bit-serial scrambler for cell-based links, on the polynomial x^43+1. The transmit lane combines each payload bit with the line bit sent a register length earlier. The receive lane undoes that by combining each incoming bit with the line bit it received a register length earlier. Both lanes remember what went over the line, so after one register length of payload bits their histories agree. The two ends therefore never need a shared starting state.

Each lane takes a serial bit with a valid strobe and a payload flag. Header bits and idle cycles pass through and leave the history untouched. The receive lane also has a synchronisation input, driven by the cell framer, that holds off descrambling until cell boundaries are known. Either lane can be put in bypass, where data passes unchanged but the history still records the line. The register length and the two reset seeds are parameters. This lets a short instance be exercised alongside the full 43-stage one.

Top module: `scr_pair`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, both `tx_out_valid` and `rx_out_valid` are 0 and both output bits are 0.
- R2: Call a transmit cycle with `tx_valid`=1, `tx_payload`=1 and `tx_bypass`=0 a scrambled cycle. On such a cycle the output bit is the input bit XOR the line bit sent LEN payload positions earlier. For the k-th payload bit after reset (k = 0..LEN-1), that line bit is taken from `TX_SEED[LEN-1-k]`.
- R3: Call a receive cycle with `rx_valid`=1, `rx_payload`=1, `rx_sync_ok`=1 and `rx_bypass`=0 a descrambled cycle. On such a cycle the output bit is the incoming bit XOR the incoming bit from LEN payload positions earlier. For the k-th payload bit after reset (k < LEN), that earlier bit is taken from `RX_SEED[LEN-1-k]`. The history records incoming bits, not recovered bits.
- R4: A valid bit with the payload flag at 0 comes out unchanged and does not advance the history of that lane.
- R5: Each output valid equals its input valid one clock earlier. A cycle with input valid at 0 does not advance the history.
- R6: A receive bit that arrives while `rx_sync_ok`=0 comes out unchanged and does not advance the receive history.
- R7: With a lane's bypass at 1, its output bit equals its input bit. The history keeps recording line bits, so descrambling is correct on the very next payload bit after bypass ends.
- R8: When the transmit output feeds the receive input, the recovered bit equals the original bit on every payload bit after the first LEN aligned payload bits. This holds for any pair of seeds and any LEN.
- R9: One inverted line bit corrupts exactly two recovered payload bits, and these lie LEN payload positions apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Transmit input bit is valid |
| tx_payload | input | 1 | Transmit bit belongs to payload (1) or header (0) |
| tx_bypass | input | 1 | Transmit lane passes data unchanged |
| tx_bit | input | 1 | Plain transmit bit |
| tx_out_valid | output | 1 | Transmit output valid |
| tx_out_bit | output | 1 | Line bit toward the link |
| rx_valid | input | 1 | Receive input bit is valid |
| rx_payload | input | 1 | Receive bit belongs to payload (1) or header (0) |
| rx_sync_ok | input | 1 | Cell framing is synchronised; enables descrambling |
| rx_bypass | input | 1 | Receive lane passes data unchanged |
| rx_bit | input | 1 | Line bit from the link |
| rx_out_valid | output | 1 | Receive output valid |
| rx_out_bit | output | 1 | Recovered plain bit |

## Verification
The transmit output is looped into the receive input at two register lengths, 5 and 43, each with different seeds on the two ends. Random payload with valid gaps checks the scrambling and descrambling arithmetic on every bit. Header bits mixed into the payload show that the history freezes on them rather than on payload bits. A stretch with synchronisation low, and stretches of bypass on either side, separate "resynchronise after LEN bits" from "keep tracking while bypassed". A single inverted line bit must yield exactly two recovered errors, LEN positions apart. That count separates a true x^43+1 descrambler from one that feeds back its own output.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {
    SCR_TX = 1'b0,
    SCR_RX = 1'b1
  } scr_dir_e;
endpackage

// File: rtl/scr_shreg.sv
module scr_shreg #(
  parameter int LEN = 43,
  parameter logic [LEN-1:0] SEED = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic tap
);
  logic [LEN-1:0] stages;

  always_ff @(posedge clk) begin
    if (rst) stages <= SEED;
    else if (en) stages <= {stages[LEN-2:0], din};
  end

  assign tap = stages[LEN-1];

  // R5 / R4: a stage may only take the bit offered on a shifting cycle
  a_r5_newest_stage: assert property (@(posedge clk) disable iff (rst)
    en |=> stages[0] == $past(din));
  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(stages));
endmodule

// File: rtl/scr_lane.sv
module scr_lane
  import scr_pkg::*;
#(
  parameter int LEN = 43,
  parameter logic [LEN-1:0] SEED = '0,
  parameter scr_dir_e DIR = SCR_TX
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_payload,
  input  logic in_gate,
  input  logic in_bypass,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);
  logic active;
  logic tap;
  logic next_bit;
  logic line_bit;

  assign active   = in_valid & in_payload & in_gate;
  assign next_bit = (active && !in_bypass) ? (in_bit ^ tap) : in_bit;

  generate
    if (DIR == SCR_RX) begin : g_rx_line
      assign line_bit = in_bit;
    end else begin : g_tx_line
      assign line_bit = next_bit;
    end
  endgenerate

  scr_shreg #(.LEN(LEN), .SEED(SEED)) u_hist (
    .clk (clk),
    .rst (rst),
    .en  (active),
    .din (line_bit),
    .tap (tap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_bit   <= next_bit;
    end
  end

  a_r5_valid_follow: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid) || $past(rst));
  a_r4_header_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_payload) |=> out_bit == $past(in_bit));
  a_r6_gate_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_gate) |=> out_bit == $past(in_bit));
  a_r7_bypass_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_bypass) |=> out_bit == $past(in_bit));
endmodule

// File: rtl/scr_pair.sv
module scr_pair
  import scr_pkg::*;
#(
  parameter int LEN = 43,
  parameter logic [LEN-1:0] TX_SEED = '0,
  parameter logic [LEN-1:0] RX_SEED = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_valid,
  input  logic tx_payload,
  input  logic tx_bypass,
  input  logic tx_bit,
  output logic tx_out_valid,
  output logic tx_out_bit,
  input  logic rx_valid,
  input  logic rx_payload,
  input  logic rx_sync_ok,
  input  logic rx_bypass,
  input  logic rx_bit,
  output logic rx_out_valid,
  output logic rx_out_bit
);
  scr_lane #(.LEN(LEN), .SEED(TX_SEED), .DIR(SCR_TX)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (tx_valid),
    .in_payload (tx_payload),
    .in_gate    (1'b1),
    .in_bypass  (tx_bypass),
    .in_bit     (tx_bit),
    .out_valid  (tx_out_valid),
    .out_bit    (tx_out_bit)
  );

  scr_lane #(.LEN(LEN), .SEED(RX_SEED), .DIR(SCR_RX)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (rx_valid),
    .in_payload (rx_payload),
    .in_gate    (rx_sync_ok),
    .in_bypass  (rx_bypass),
    .in_bit     (rx_bit),
    .out_valid  (rx_out_valid),
    .out_bit    (rx_out_bit)
  );

  // R1: outputs stay cleared on the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!tx_out_valid && !rx_out_valid && !tx_out_bit && !rx_out_bit));
endmodule

// File: tb/scr_pair_test.sv
module scr_chain #(
  parameter int L = 5,
  parameter logic [L-1:0] TS = '0,
  parameter logic [L-1:0] RS = '0
) (
  input logic clk,
  input logic rst,
  input logic v,
  input logic pl,
  input logic d,
  input logic tbyp,
  input logic rbyp,
  input logic sync,
  input logic flip
);
  logic tx_ov, tx_ob, rx_ov, rx_ob;
  logic pl_d, rb_d, sy_d, fl_d;

  always_ff @(posedge clk) begin
    pl_d <= pl;
    rb_d <= rbyp;
    sy_d <= sync;
    fl_d <= flip;
  end

  scr_pair #(.LEN(L), .TX_SEED(TS), .RX_SEED(RS)) uut (
    .clk(clk), .rst(rst),
    .tx_valid(v), .tx_payload(pl), .tx_bypass(tbyp), .tx_bit(d),
    .tx_out_valid(tx_ov), .tx_out_bit(tx_ob),
    .rx_valid(tx_ov), .rx_payload(pl_d), .rx_sync_ok(sy_d), .rx_bypass(rb_d),
    .rx_bit(tx_ob ^ fl_d),
    .rx_out_valid(rx_ov), .rx_out_bit(rx_ob)
  );

  int tests = 0, fails = 0, errs = 0, rec = 0, e_prev = -1, e_last = -1;
  int tcnt, rcnt, run, idx;
  bit th [0:4095];
  bit rh [0:4095];
  logic texp, rexp, prior, line;
  logic pv, ppl, psy, pd, ptb, prb, pfl, ptexp;

  always begin
    @(posedge clk);
    #2;
    if (rst) begin
      tests++;
      if (tx_ov !== 1'b0 || tx_ob !== 1'b0 || rx_ov !== 1'b0 || rx_ob !== 1'b0) begin
        fails++;
        $display("FAIL R1 L=%0d actual=%b%b%b%b expected=0000", L, tx_ov, tx_ob, rx_ov, rx_ob);
      end
      tcnt = 0; rcnt = 0; run = 0; pv = 0;
    end else begin
      // transmit lane, inputs of this step (R2, R4, R5, R7)
      texp = d;
      if (v && pl) begin
        prior = (tcnt < L) ? TS[L-1-tcnt] : th[tcnt-L];
        if (!tbyp) texp = d ^ prior;
        th[tcnt] = texp;
        tcnt++;
      end
      tests++;
      if (tx_ov !== v) begin
        fails++;
        $display("FAIL R5 tx valid L=%0d actual=%b expected=%b", L, tx_ov, v);
      end
      if (v) begin
        tests++;
        if (tx_ob !== texp) begin
          fails++;
          $display("FAIL %s tx bit L=%0d actual=%b expected=%b",
                   tbyp ? "R7" : (pl ? "R2" : "R4"), L, tx_ob, texp);
        end
      end
      // receive lane, bit of previous step (R3, R4, R6, R7, R8)
      tests++;
      if (rx_ov !== pv) begin
        fails++;
        $display("FAIL R5 rx valid L=%0d actual=%b expected=%b", L, rx_ov, pv);
      end
      if (pv) begin
        line = ptexp ^ pfl;
        rexp = line;
        if (ppl && psy) begin
          prior = (rcnt < L) ? RS[L-1-rcnt] : rh[rcnt-L];
          if (!prb) rexp = line ^ prior;
          rh[rcnt] = line;
          idx = rcnt;
          rcnt++;
          if (run >= L && !ptb && !prb) begin
            rec++;
            if (rx_ob !== pd) begin
              errs++;
              e_prev = e_last;
              e_last = idx;
            end
          end
          run++;
        end else if (ppl) begin
          run = 0;
        end
        tests++;
        if (rx_ob !== rexp) begin
          fails++;
          $display("FAIL %s rx bit L=%0d actual=%b expected=%b",
                   prb ? "R7" : (!psy ? "R6" : (ppl ? "R3" : "R4")), L, rx_ob, rexp);
        end
      end
      pv = v; ppl = pl; psy = sync; pd = d; ptb = tbyp; prb = rbyp; pfl = flip; ptexp = texp;
    end
  end
endmodule

module scr_pair_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v = 0, pl = 0, d = 0, tbyp = 0, rbyp = 0, sync = 1, flip = 0;
  int tests = 0, fails = 0;
  int b5, b43, r5, r43;

  always #5 clk = ~clk;

  scr_chain #(.L(5), .TS(5'b10110), .RS(5'b01011)) h5 (
    .clk(clk), .rst(rst), .v(v), .pl(pl), .d(d), .tbyp(tbyp), .rbyp(rbyp),
    .sync(sync), .flip(flip));
  scr_chain #(.L(43), .TS(43'h2AB_CDEF_0123), .RS(43'h155_5555_5555)) h43 (
    .clk(clk), .rst(rst), .v(v), .pl(pl), .d(d), .tbyp(tbyp), .rbyp(rbyp),
    .sync(sync), .flip(flip));

  task automatic step(input logic iv, input logic ipl, input logic id, input logic itb,
                      input logic irb, input logic isy, input logic ifl);
    @(negedge clk);
    v = iv; pl = ipl; d = id; tbyp = itb; rbyp = irb; sync = isy; flip = ifl;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mark();
    b5 = h5.errs; b43 = h43.errs; r5 = h5.rec; r43 = h43.rec;
  endtask

  task automatic drain();
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic clean_checks(input string tag);
    chk(h5.errs == b5, {tag, " L=5 recovery errors"}, h5.errs - b5, 0);
    chk(h43.errs == b43, {tag, " L=43 recovery errors"}, h43.errs - b43, 0);
    chk(h5.rec > r5, {tag, " L=5 compared bits"}, h5.rec - r5, 1);
    chk(h43.rec > r43, {tag, " L=43 compared bits"}, h43.rec - r43, 1);
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: random payload with valid gaps, distinct seeds
    mark();
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 9) != 0, 1, $urandom_range(0, 1), 0, 0, 1, 0);
    drain();
    clean_checks("R8 random");

    // R4: header bits interleaved with payload
    mark();
    for (int i = 0; i < 300; i++)
      step(1, (i % 12) >= 4, $urandom_range(0, 1), 0, 0, 1, 0);
    drain();
    clean_checks("R4 headers");

    // R6: framing lost for a stretch, then resynchronise
    for (int i = 0; i < 30; i++) step(1, 1, $urandom_range(0, 1), 0, 0, 0, 0);
    mark();
    for (int i = 0; i < 200; i++) step(1, 1, $urandom_range(0, 1), 0, 0, 1, 0);
    drain();
    clean_checks("R6 resync");

    // R7: bypass on each side while history keeps tracking
    for (int i = 0; i < 30; i++) step(1, 1, $urandom_range(0, 1), 1, 0, 1, 0);
    for (int i = 0; i < 30; i++) step(1, 1, $urandom_range(0, 1), 0, 1, 1, 0);
    mark();
    for (int i = 0; i < 100; i++) step(1, 1, $urandom_range(0, 1), 0, 0, 1, 0);
    drain();
    clean_checks("R7 after bypass");

    // R9: a single inverted line bit
    for (int i = 0; i < 100; i++) step(1, 1, $urandom_range(0, 1), 0, 0, 1, 0);
    mark();
    step(1, 1, $urandom_range(0, 1), 0, 0, 1, 1);
    for (int i = 0; i < 100; i++) step(1, 1, $urandom_range(0, 1), 0, 0, 1, 0);
    drain();
    chk(h5.errs - b5 == 2, "R9 L=5 error count", h5.errs - b5, 2);
    chk(h5.e_last - h5.e_prev == 5, "R9 L=5 error spacing", h5.e_last - h5.e_prev, 5);
    chk(h43.errs - b43 == 2, "R9 L=43 error count", h43.errs - b43, 2);
    chk(h43.e_last - h43.e_prev == 43, "R9 L=43 error spacing", h43.e_last - h43.e_prev, 43);

    $display("[TB] %0d tests run, %0d failed",
             tests + h5.tests + h43.tests, fails + h5.fails + h43.fails);
    $finish;
  end

  initial begin
    #2_000_000;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed",
             tests + h5.tests + h43.tests + 1, fails + h5.fails + h43.fails + 1);
    $finish;
  end
endmodule